// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests for a CPU and drives two request lines toward it: a normal request and a fast request. The normal side has 23 internal sources and 4 external pins, 27 sources in all. Internal sources are synchronous level signals. Each external pin first passes through a two-flop synchronizer and is then read either as a level of selectable polarity or as an edge of selectable direction. A separate fast-request pin always triggers on a falling edge and bypasses the priority logic.

Each normal source carries a 3-bit priority from 0 to 7. Among pending, enabled sources the highest priority wins. Equal priorities go to the lowest source number. Software takes an interrupt by reading the vector register. That read returns the winner and raises the current masking level, so only strictly higher priorities can interrupt. A write to the same register ends the interrupt and restores the level saved before. Nesting reaches eight deep, one step per priority.

The register port has single-cycle read and write strobes, a 4-bit word address and 32-bit data. Read data is combinational from the address.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o and fiq_o are low, the enable register (address 0) and the current level (address 4, bits [3:0]) read 0, and the vector register (address 3) reads 0.
- R2: Internal source i (0..22) is pending, and shows as bit i of the pending register (address 1), exactly while int_src_i[i] is high. No synchronizer sits on this path.
- R3: External pin k (source 23+k) is set by bits [2k+1:2k] of the configuration register (address 2). Bit 2k = 1 selects edge mode. Bit 2k+1 = 1 selects active-low level or falling edge. In level mode the source is pending while the synchronized pin is active. The pin passes two flops, so a change does not show before two clock edges.
- R4: In edge mode, a selected edge latches a pending bit that stays set after the pin returns. The bit clears only when 1 is written to its position in the pending register. The opposite edge has no effect.
- R5: A falling edge on fiq_pin_n_i sets fiq_o, which does not depend on the enable register or the level. fiq_o stays high until 1 is written to bit 0 of address 5, which reads the state in bit 0. A rising edge has no effect.
- R6: Priorities occupy 3-bit fields. Source s sits in register 8 + s/8 at bits [4*(s%8)+2 : 4*(s%8)]. The winner is the pending, enabled source with the highest priority, and ties go to the lowest source number. A vector read returns bit 31 = 1, bits [10:8] = priority and bits [4:0] = source number.
- R7: irq_o is high only when the winner's priority plus one exceeds the current level. A vector read that returns a winner sets the level to that priority plus one, which masks equal and lower priorities.
- R8: A write to address 3 restores the level in force before the latest vector read. Up to eight reads nest. A write at level 0 leaves the level at 0.
- R9: A source whose enable bit is 0 never raises irq_o or wins a vector read, yet it still shows in the pending register.
- R10: A vector read when no source qualifies returns 0 and leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_src_i | input | 23 | Internal level requests |
| ext_pin_i | input | 4 | External request pins, asynchronous |
| fiq_pin_n_i | input | 1 | Fast request pin, falling edge |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (vector read side effect) |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check on every cycle that a latched edge stays pending until cleared, that the nesting store never overflows, that a taking read raises the level to the winner's step, and that an end-of-interrupt lowers it. They also check that irq_o never rises without an enabled pending source and that the fast request holds until cleared. Only the bench scenarios can show which source wins: ties, masking at the current level, the choice of polarity and edge per pin, and the exact synchronizer latency.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int PIC_NUM_INT = 23;
  localparam int PIC_NUM_EXT = 4;
  localparam int PIC_PRIO_W  = 3;

  // edge of the chosen direction between two successive samples
  function automatic logic edge_hit(input logic now_v, input logic prev_v,
                                    input logic falling);
    return falling ? (prev_v & ~now_v) : (now_v & ~prev_v);
  endfunction

  // bit offset of a source's priority field inside its register
  function automatic int prio_field_lsb(input int src, input int slots, input int slot_w);
    return (src % slots) * slot_w;
  endfunction
endpackage

// File: rtl/pic_sense.sv
`timescale 1ns/1ps
module pic_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic invert_i,
  input  logic clr_i,
  output logic pend_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic latch_q;
  logic pin_s;
  logic edge_seen;

  assign pin_s     = sync_q[SYNC_STAGES-1];
  assign edge_seen = pic_pkg::edge_hit(pin_s, prev_q, invert_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= pin_s;
      if (!edge_mode_i)   latch_q <= 1'b0;
      else if (edge_seen) latch_q <= 1'b1;
      else if (clr_i)     latch_q <= 1'b0;
    end
  end

  assign pend_o = edge_mode_i ? latch_q : (pin_s ^ invert_i);

  AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && edge_seen) |=> (pend_o || !edge_mode_i)); // R4
  AST_CLEAR_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && clr_i && !edge_seen) |=> (!pend_o || !edge_mode_i)); // R4
endmodule

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
module pic_arbiter #(
  parameter int NUM_SRC = 27,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      hit_o,
  output logic [ID_W-1:0]           id_o,
  output logic [PRIO_W-1:0]         prio_o
);
  // ascending scan with strict compare: lowest number keeps a tie
  always_comb begin
    hit_o  = 1'b0;
    id_o   = '0;
    prio_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (!hit_o || (prio_i[i*PRIO_W +: PRIO_W] > prio_o))) begin
        hit_o  = 1'b1;
        id_o   = ID_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/pic_nest.sv
`timescale 1ns/1ps
module pic_nest #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int DEPTH_W = $clog2(DEPTH + 1);
  localparam int IDX_W   = $clog2(DEPTH);

  logic [LVL_W-1:0]   stk_q [DEPTH];
  logic [LVL_W-1:0]   cur_q;
  logic [DEPTH_W-1:0] sp_q;
  logic               has_room;

  assign has_room = (sp_q < DEPTH_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      sp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else if (pop_i) begin
      if (sp_q != '0) begin
        cur_q <= stk_q[IDX_W'(sp_q - 1'b1)];
        sp_q  <= sp_q - 1'b1;
      end
    end else if (push_i && has_room) begin
      stk_q[sp_q[IDX_W-1:0]] <= cur_q;
      cur_q <= lvl_i;
      sp_q  <= sp_q + 1'b1;
    end
  end

  assign lvl_o = cur_q;

  AST_NEST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> has_room); // R8
  AST_NEST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |=> (lvl_o > $past(lvl_o))); // R7
  AST_EOI_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && sp_q == '0) |=> $stable(lvl_o)); // R8
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int NUM_INT     = pic_pkg::PIC_NUM_INT,
  parameter int NUM_EXT     = pic_pkg::PIC_NUM_EXT,
  parameter int PRIO_W      = pic_pkg::PIC_PRIO_W,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_src_i,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic               fiq_pin_n_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NUM_SRC       = NUM_INT + NUM_EXT;
  localparam int ID_W          = $clog2(NUM_SRC);
  localparam int LVL_W         = PRIO_W + 1;
  localparam int NEST_DEPTH    = 1 << PRIO_W;
  localparam int SLOT_W        = 4;
  localparam int SLOTS_PER_REG = DATA_W / SLOT_W;
  localparam int PRIO_BASE     = 8;
  localparam int VEC_PRIO_LSB  = 8;

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_FIQ  = ADDR_W'(5);

  logic [NUM_SRC-1:0]        en_q;
  logic [2*NUM_EXT-1:0]      cfg_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;

  logic [NUM_EXT-1:0] ext_pend;
  logic [NUM_SRC-1:0] pend_all;
  logic [NUM_SRC-1:0] req;
  logic               win_hit;
  logic [ID_W-1:0]    win_id;
  logic [PRIO_W-1:0]  win_prio;
  logic [LVL_W-1:0]   win_lvl;
  logic [LVL_W-1:0]   cur_lvl;
  logic [DATA_W-1:0]  vec_word;

  // named bus events
  logic wr_en, wr_cfg, wr_pend, wr_fiq, vec_read, eoi, fiq_clr;
  logic unused_wbits;

  assign wr_en    = bus_wr_i && (bus_addr_i == A_EN);
  assign wr_cfg   = bus_wr_i && (bus_addr_i == A_CFG);
  assign wr_pend  = bus_wr_i && (bus_addr_i == A_PEND);
  assign wr_fiq   = bus_wr_i && (bus_addr_i == A_FIQ);
  assign eoi      = bus_wr_i && (bus_addr_i == A_VEC);
  assign vec_read = bus_rd_i && (bus_addr_i == A_VEC);
  assign fiq_clr  = wr_fiq && bus_wdata_i[0];
  assign unused_wbits = ^bus_wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cfg_q  <= '0;
      prio_q <= '0;
    end else begin
      if (wr_en)  en_q  <= bus_wdata_i[NUM_SRC-1:0];
      if (wr_cfg) cfg_q <= bus_wdata_i[2*NUM_EXT-1:0];
      for (int s = 0; s < NUM_SRC; s++) begin
        if (bus_wr_i && bus_addr_i == ADDR_W'(PRIO_BASE + s / SLOTS_PER_REG))
          prio_q[s*PRIO_W +: PRIO_W] <=
            bus_wdata_i[pic_pkg::prio_field_lsb(s, SLOTS_PER_REG, SLOT_W) +: PRIO_W];
      end
    end
  end

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    pic_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (ext_pin_i[k]),
      .edge_mode_i(cfg_q[2*k]),
      .invert_i   (cfg_q[2*k+1]),
      .clr_i      (wr_pend && bus_wdata_i[NUM_INT+k]),
      .pend_o     (ext_pend[k])
    );
  end

  pic_sense #(.SYNC_STAGES(SYNC_STAGES)) u_fiq_sense (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (fiq_pin_n_i),
    .edge_mode_i(1'b1),
    .invert_i   (1'b1),
    .clr_i      (fiq_clr),
    .pend_o     (fiq_o)
  );

  assign pend_all = {ext_pend, int_src_i};
  assign req      = pend_all & en_q;

  pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .req_i (req),
    .prio_i(prio_q),
    .hit_o (win_hit),
    .id_o  (win_id),
    .prio_o(win_prio)
  );

  assign win_lvl = LVL_W'(win_prio) + LVL_W'(1);
  assign irq_o   = win_hit && (win_lvl > cur_lvl);

  pic_nest #(.DEPTH(NEST_DEPTH), .LVL_W(LVL_W)) u_nest (
    .clk   (clk),
    .rst_n (rst_n),
    .push_i(vec_read && irq_o),
    .pop_i (eoi),
    .lvl_i (win_lvl),
    .lvl_o (cur_lvl)
  );

  always_comb begin
    vec_word = '0;
    if (irq_o) begin
      vec_word[DATA_W-1]                 = 1'b1;
      vec_word[VEC_PRIO_LSB +: PRIO_W]   = win_prio;
      vec_word[ID_W-1:0]                 = win_id;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_EN:    bus_rdata_o = DATA_W'(en_q);
      A_PEND:  bus_rdata_o = DATA_W'(pend_all);
      A_CFG:   bus_rdata_o = DATA_W'(cfg_q);
      A_VEC:   bus_rdata_o = vec_word;
      A_LVL:   bus_rdata_o = DATA_W'(cur_lvl);
      A_FIQ:   bus_rdata_o = DATA_W'(fiq_o);
      default: bus_rdata_o = '0;
    endcase
    for (int s = 0; s < NUM_SRC; s++) begin
      if (bus_addr_i == ADDR_W'(PRIO_BASE + s / SLOTS_PER_REG))
        bus_rdata_o[pic_pkg::prio_field_lsb(s, SLOTS_PER_REG, SLOT_W) +: PRIO_W] =
          prio_q[s*PRIO_W +: PRIO_W];
    end
  end

  AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend_all & en_q))); // R9
  AST_WIN_IS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> req[win_id]); // R6
  AST_VEC_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_read && irq_o && !eoi) |=> (cur_lvl == $past(win_lvl))); // R7
  AST_EOI_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && cur_lvl != '0) |=> (cur_lvl < $past(cur_lvl))); // R8
  AST_EMPTY_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_read && !irq_o && !eoi) |=> $stable(cur_lvl)); // R10
  AST_FIQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !fiq_clr) |=> fiq_o); // R5
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] int_src = '0;
  logic [3:0]  ext_pin = '0;
  logic        fiq_n = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, fiq;
  logic        pin_chk = 1'b0;
  logic        done = 1'b0;
  int          n_tests = 0;
  int          n_fail = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  localparam logic [3:0] A_EN = 4'd0, A_PEND = 4'd1, A_CFG = 4'd2, A_VEC = 4'd3,
                         A_LVL = 4'd4, A_FIQ = 4'd5;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .int_src_i(int_src), .ext_pin_i(ext_pin),
    .fiq_pin_n_i(fiq_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  // monitor: compares each observation against the next expected item
  always @(negedge clk) begin
    if (rst_n && (bus_rd || pin_chk)) begin
      logic [31:0] act;
      act = bus_rd ? bus_rdata : {30'd0, fiq, irq};
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("[TB] FAIL R1 scoreboard empty: actual=%h expected=none", act);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (act !== it.exp) begin
          n_fail++;
          $display("[TB] FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    step();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic bus_check(input logic [3:0] a, input logic [31:0] e, input string tag);
    sb_q.push_back('{exp: e, tag: tag});
    step();
    bus_rd = 1'b1; bus_addr = a;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic pin_check(input logic [1:0] e, input string tag);
    sb_q.push_back('{exp: {30'd0, e}, tag: tag});
    step();
    pin_chk = 1'b1;
    step();
    pin_chk = 1'b0;
  endtask

  initial begin
    idle(3); #1 rst_n = 1'b1;
    idle(3);
    // R1 reset state
    pin_check(2'b00, "R1 pins after reset");
    bus_check(A_EN, 32'h0, "R1 enable reset");
    bus_check(A_LVL, 32'h0, "R1 level reset");
    bus_check(A_VEC, 32'h0, "R1 vector reset");

    // priorities: src5 = 2
    bus_write(4'd8, 32'h0020_0000);
    bus_check(4'd8, 32'h0020_0000, "R6 priority readback");
    bus_write(A_EN, 32'h07FF_FFFF);

    // R2 internal level source
    step(); int_src[5] = 1'b1;
    pin_check(2'b01, "R2 internal source raises irq");
    bus_check(A_PEND, 32'h0000_0020, "R2 pending bit 5");
    bus_check(A_VEC, 32'h8000_0205, "R6 vector src5 prio2");
    bus_check(A_LVL, 32'd3, "R7 level after take");
    pin_check(2'b00, "R7 equal priority masked");
    bus_write(A_VEC, 32'h0);
    bus_check(A_LVL, 32'd0, "R8 level restored");
    pin_check(2'b01, "R7 irq returns after end");

    // R6 tie on equal priorities
    step(); int_src[9] = 1'b1;
    bus_write(4'd9, 32'h0000_0020);
    bus_check(A_VEC, 32'h8000_0205, "R6 tie goes to lower number");
    bus_write(A_VEC, 32'h0);
    bus_write(4'd9, 32'h0000_0050);
    bus_check(A_VEC, 32'h8000_0509, "R6 higher priority wins");
    // nesting
    bus_write(4'd10, 32'h0006_0000);
    step(); int_src[20] = 1'b1;
    pin_check(2'b01, "R7 higher priority preempts level");
    bus_check(A_VEC, 32'h8000_0614, "R7 nested vector src20");
    bus_check(A_LVL, 32'd7, "R8 nested level");
    pin_check(2'b00, "R7 masked at top level");
    bus_write(A_VEC, 32'h0);
    bus_check(A_LVL, 32'd6, "R8 inner end restores outer");
    bus_write(A_VEC, 32'h0);
    bus_write(A_VEC, 32'h0);
    bus_check(A_LVL, 32'd0, "R8 end at level 0 no effect");

    // R9 disabled sources
    bus_write(A_EN, 32'h0);
    pin_check(2'b00, "R9 disabled no irq");
    bus_check(A_PEND, 32'h0010_0220, "R9 pending still visible");
    bus_check(A_VEC, 32'h0, "R10 empty vector");
    bus_check(A_LVL, 32'd0, "R10 level unchanged");
    bus_write(A_EN, 32'h07EF_FFFF);
    bus_check(A_VEC, 32'h8000_0509, "R9 disabled src20 skipped");

    // R10 nothing above current level
    step(); int_src[9] = 1'b0; int_src[20] = 1'b0;
    bus_check(A_VEC, 32'h0, "R10 lower source not taken");
    bus_check(A_LVL, 32'd6, "R10 level held");
    pin_check(2'b00, "R7 lower priority masked");
    bus_write(A_VEC, 32'h0);
    step(); int_src = '0;
    bus_write(A_EN, 32'h07FF_FFFF);

    // R3 external level, src23 prio 4
    bus_write(4'd10, 32'h4006_0000);
    step(); ext_pin[0] = 1'b1;
    bus_check(A_PEND, 32'h0, "R3 synchronizer latency");
    idle(4);
    bus_check(A_PEND, 32'h0080_0000, "R3 active-high pending");
    bus_check(A_VEC, 32'h8000_0417, "R6 external vector src23");
    bus_write(A_VEC, 32'h0);
    step(); ext_pin[0] = 1'b0;
    idle(4);
    bus_check(A_PEND, 32'h0, "R3 level drops with pin");
    bus_write(A_CFG, 32'h2);
    idle(1);
    bus_check(A_PEND, 32'h0080_0000, "R3 active-low pending");
    step(); ext_pin[0] = 1'b1;
    idle(4);
    bus_check(A_PEND, 32'h0, "R3 active-low released");

    // R4 external edge, src24 prio 7
    bus_write(A_CFG, 32'h6);
    bus_write(4'd11, 32'h7);
    step(); ext_pin[1] = 1'b1;
    idle(4);
    bus_check(A_PEND, 32'h0100_0000, "R4 rising edge latched");
    step(); ext_pin[1] = 1'b0;
    idle(4);
    bus_check(A_PEND, 32'h0100_0000, "R4 latch held after pin low");
    bus_check(A_VEC, 32'h8000_0718, "R4 edge source vector");
    bus_write(A_VEC, 32'h0);
    bus_write(A_PEND, 32'h0100_0000);
    bus_check(A_PEND, 32'h0, "R4 write-one clears");
    bus_write(A_CFG, 32'hE);
    idle(2);
    step(); ext_pin[1] = 1'b1;
    idle(4);
    bus_check(A_PEND, 32'h0, "R4 rising ignored in falling mode");
    step(); ext_pin[1] = 1'b0;
    idle(4);
    bus_check(A_PEND, 32'h0100_0000, "R4 falling edge latched");
    bus_write(A_PEND, 32'h0100_0000);
    bus_check(A_PEND, 32'h0, "R4 cleared again");

    // R5 fast request
    bus_write(A_EN, 32'h0);
    step(); fiq_n = 1'b0;
    idle(4);
    pin_check(2'b10, "R5 falling edge sets fiq");
    bus_check(A_FIQ, 32'h1, "R5 fiq status");
    step(); fiq_n = 1'b1;
    idle(4);
    pin_check(2'b10, "R5 rising edge no effect");
    bus_write(A_FIQ, 32'h1);
    pin_check(2'b00, "R5 fiq cleared");
    bus_check(A_FIQ, 32'h0, "R5 fiq status cleared");

    wait (sb_q.size() == 0);
    idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL R1 watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule